// File: doc/BRIEF.md
# Multi-context CRC engine

This block computes cyclic redundancy checksums for up to three data streams at once. Each stream owns a context: a width selection that also picks the generator polynomial, a seed, and a running checksum. A producer can send words for different streams on consecutive cycles in any order, and each word is folded into its own context's checksum in the same clock edge that accepts it.

Access is through a flat register port. A write names a context and one of its registers: the data input, the seed or the configuration. A combinational read port returns a context's checksum, seed or configuration. The checksum is not reflected and has no final XOR, so software applies any output inversion a given standard needs.

Top module: `crc_ctx_engine`

## Requirements
- R1: Each of the three contexts holds its own width, seed and checksum; a write addressed to one context leaves the other two unchanged.
- R2: Register selector codes are 0 = data input on write and checksum on read, 1 = seed, 2 = configuration, 3 = unused. Configuration bits [1:0] pick the width: 0 gives 8 bits with polynomial 0x1D, 1 gives 16 bits with 0x1021, 2 and 3 both give 32 bits with 0x04C11DB7.
- R3: A data write folds the 32-bit word into the addressed checksum, most significant bit first, with no reflection. The new value is readable in the cycle after the accepting edge.
- R4: A write on every clock cycle, with any mix of contexts, is absorbed without loss.
- R5: A seed write stores the value, which reads back in full, and loads it at once into that context's checksum.
- R6: A configuration write stores bits [1:0], reads back zero-extended, and reloads the checksum from the context's current seed.
- R7: A checksum read returns only the low 8, 16 or 32 bits that the context's width selects, zero-extended.
- R8: After reset every context has width code 0, seed 0 and checksum 0.
- R9: A write to context index 3 or to selector 3 changes nothing, and a read of either returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one register access per cycle |
| wr_ctx | input | 2 | Context index of the write |
| wr_reg | input | 2 | Register selector of the write |
| wr_data | input | 32 | Write data: input word, seed or configuration |
| rd_ctx | input | 2 | Context index of the read |
| rd_reg | input | 2 | Register selector of the read |
| rd_data | output | 32 | Read data, combinational from the selected register |

## Verification
A corrupted checksum bit or a wrong feedback tap is visible on the next checksum read of that context. It then stays wrong for every later word in that stream until the next seed or configuration write. A write that leaks into the wrong context shows up when a neighbouring context is read. Because of this, the streams are interleaved at full rate and each one is read back often. A stale seed or a missing reload appears in the first read after the configuration write.

// File: rtl/crc_ctx_pkg.sv
package crc_ctx_pkg;

   localparam int CRC_MAX_W    = 32;
   localparam int NUM_VARIANTS = 3;

   typedef enum logic [1:0] {
      REG_DATA = 2'd0,
      REG_SEED = 2'd1,
      REG_CFG  = 2'd2,
      REG_NONE = 2'd3
   } crc_reg_e;

   // variant index 0/1/2 -> 8/16/32 bit
   function automatic int variant_width(input int v);
      return (v == 0) ? 8 : (v == 1) ? 16 : 32;
   endfunction

   function automatic logic [CRC_MAX_W-1:0] variant_poly(input int v);
      return (v == 0) ? 32'h0000_001D : (v == 1) ? 32'h0000_1021 : 32'h04C1_1DB7;
   endfunction

   // width code from configuration -> variant index (code 3 folds onto 32 bit)
   function automatic logic [1:0] code_to_variant(input logic [1:0] code);
      return (code == 2'd3) ? 2'd2 : code;
   endfunction

   function automatic logic [CRC_MAX_W-1:0] code_mask(input logic [1:0] code);
      case (code)
         2'd0:    return 32'h0000_00FF;
         2'd1:    return 32'h0000_FFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/crc_word_step.sv
module crc_word_step #(
   parameter int          W      = 32,
   parameter int          DATA_W = 32,
   parameter logic [31:0] POLY   = 32'h04C1_1DB7
) (
   input  logic [W-1:0]      crc_in,
   input  logic [DATA_W-1:0] data,
   output logic [W-1:0]      crc_out
);

   if (W < 1 || W > 32) begin : g_bad_w
      $error("crc_word_step: W must be 1..32");
   end

   localparam logic [W-1:0] TAPS = POLY[W-1:0];

   always_comb begin
      logic [W-1:0] acc;
      logic         fb;
      acc = crc_in;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         fb  = acc[W-1] ^ data[i];
         acc = {acc[W-2:0], 1'b0};
         if (fb) acc = acc ^ TAPS;
      end
      crc_out = acc;
   end

endmodule

// File: rtl/crc_ctx_slot.sv
module crc_ctx_slot
   import crc_ctx_pkg::*;
#(
   parameter int IDX    = 0,
   parameter int CTX_W  = 2,
   parameter int DATA_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [CTX_W-1:0]     wr_ctx,
   input  logic [1:0]           wr_reg,
   input  logic [DATA_W-1:0]    wr_data,
   output logic [CRC_MAX_W-1:0] crc_q,
   output logic [CRC_MAX_W-1:0] seed_q,
   output logic [1:0]           cfg_q
);

   logic                 hit;
   logic [CRC_MAX_W-1:0] nxt [NUM_VARIANTS];
   logic [CRC_MAX_W-1:0] step_sel;

   assign hit = wr_en && (int'(wr_ctx) == IDX);

   for (genvar v = 0; v < NUM_VARIANTS; v++) begin : g_var
      localparam int VW = variant_width(v);
      logic [VW-1:0] step_out;
      crc_word_step #(
         .W      (VW),
         .DATA_W (DATA_W),
         .POLY   (variant_poly(v))
      ) i_step (
         .crc_in  (crc_q[VW-1:0]),
         .data    (wr_data),
         .crc_out (step_out)
      );
      if (VW < CRC_MAX_W) begin : g_ext
         assign nxt[v] = {{(CRC_MAX_W-VW){1'b0}}, step_out};
      end else begin : g_full
         assign nxt[v] = step_out;
      end
   end

   always_comb begin
      case (code_to_variant(cfg_q))
         2'd0:    step_sel = nxt[0];
         2'd1:    step_sel = nxt[1];
         default: step_sel = nxt[2];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q  <= '0;
         seed_q <= '0;
         cfg_q  <= '0;
      end else if (hit) begin
         case (wr_reg)
            REG_DATA: crc_q <= step_sel;
            REG_SEED: begin
               seed_q <= wr_data[CRC_MAX_W-1:0];
               crc_q  <= wr_data[CRC_MAX_W-1:0];
            end
            REG_CFG: begin
               cfg_q <= wr_data[1:0];
               crc_q <= seed_q;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/crc_ctx_engine.sv
module crc_ctx_engine
   import crc_ctx_pkg::*;
#(
   parameter int NUM_CTX = 3,
   parameter int DATA_W  = 32,
   localparam int CTX_W  = (NUM_CTX > 2) ? $clog2(NUM_CTX + 1) : 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTX_W-1:0]  wr_ctx,
   input  logic [1:0]        wr_reg,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [CTX_W-1:0]  rd_ctx,
   input  logic [1:0]        rd_reg,
   output logic [DATA_W-1:0] rd_data
);

   if (DATA_W != CRC_MAX_W) begin : g_bad_dw
      $error("crc_ctx_engine: DATA_W must equal CRC_MAX_W");
   end
   if (NUM_CTX < 1 || NUM_CTX >= (1 << CTX_W)) begin : g_bad_ctx
      $error("crc_ctx_engine: NUM_CTX out of range for CTX_W");
   end

   logic [NUM_CTX-1:0][CRC_MAX_W-1:0] crc_st;
   logic [NUM_CTX-1:0][CRC_MAX_W-1:0] seed_st;
   logic [NUM_CTX-1:0][1:0]           cfg_st;

   for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
      crc_ctx_slot #(
         .IDX    (c),
         .CTX_W  (CTX_W),
         .DATA_W (DATA_W)
      ) i_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_en),
         .wr_ctx  (wr_ctx),
         .wr_reg  (wr_reg),
         .wr_data (wr_data),
         .crc_q   (crc_st[c]),
         .seed_q  (seed_st[c]),
         .cfg_q   (cfg_st[c])
      );
   end

   always_comb begin
      rd_data = '0;
      for (int c = 0; c < NUM_CTX; c++) begin
         if (int'(rd_ctx) == c) begin
            case (rd_reg)
               REG_DATA: rd_data = crc_st[c] & code_mask(cfg_st[c]);
               REG_SEED: rd_data = seed_st[c];
               REG_CFG:  rd_data = {{(DATA_W-2){1'b0}}, cfg_st[c]};
               default:  rd_data = '0;
            endcase
         end
      end
   end

endmodule

// File: rtl/crc_ctx_chk.sv
module crc_ctx_chk
   import crc_ctx_pkg::*;
#(
   parameter int NUM_CTX = 3,
   parameter int DATA_W  = 32,
   parameter int CTX_W   = 2
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic                              wr_en,
   input logic [CTX_W-1:0]                  wr_ctx,
   input logic [1:0]                        wr_reg,
   input logic [DATA_W-1:0]                 wr_data,
   input logic [CTX_W-1:0]                  rd_ctx,
   input logic [1:0]                        rd_reg,
   input logic [DATA_W-1:0]                 rd_data,
   input logic [NUM_CTX-1:0][CRC_MAX_W-1:0] crc_st,
   input logic [NUM_CTX-1:0][CRC_MAX_W-1:0] seed_st,
   input logic [NUM_CTX-1:0][1:0]           cfg_st
);

   for (genvar k = 0; k < NUM_CTX; k++) begin : g_iso
      // R1 and R9: a write not aimed at context k leaves its state alone
      a_r1_isolation: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && int'(wr_ctx) != k) |=>
            (crc_st[k] == $past(crc_st[k]) && seed_st[k] == $past(seed_st[k])
             && cfg_st[k] == $past(cfg_st[k])));

      // R5: seed write loads the checksum on the next edge
      a_r5_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && int'(wr_ctx) == k && wr_reg == REG_SEED) |=>
            (crc_st[k] == $past(wr_data) && seed_st[k] == $past(wr_data)));

      // R6: configuration write reloads the checksum from the held seed
      a_r6_cfg_reload: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && int'(wr_ctx) == k && wr_reg == REG_CFG) |=>
            (crc_st[k] == $past(seed_st[k])));

      // R7: checksum read carries nothing above the selected width
      a_r7_masked_read: assert property (@(posedge clk) disable iff (!rst_n)
         (int'(rd_ctx) == k && rd_reg == REG_DATA && cfg_st[k] == 2'd0) |->
            (rd_data[DATA_W-1:8] == '0));
   end

   // R9: read of an absent context returns zero
   a_r9_bad_ctx_read: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rd_ctx) >= NUM_CTX) |-> (rd_data == '0));

endmodule

bind crc_ctx_engine crc_ctx_chk #(
   .NUM_CTX (NUM_CTX),
   .DATA_W  (DATA_W),
   .CTX_W   (CTX_W)
) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_ctx  (wr_ctx),
   .wr_reg  (wr_reg),
   .wr_data (wr_data),
   .rd_ctx  (rd_ctx),
   .rd_reg  (rd_reg),
   .rd_data (rd_data),
   .crc_st  (crc_st),
   .seed_st (seed_st),
   .cfg_st  (cfg_st)
);

// File: tb/test_crc_ctx_engine.sv
module test_crc_ctx_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_ctx = '0;
   logic [1:0]  wr_reg = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_ctx = '0;
   logic [1:0]  rd_reg = '0;
   logic [31:0] rd_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   crc_ctx_engine i_crc_ctx_engine (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctx(wr_ctx), .wr_reg(wr_reg),
      .wr_data(wr_data), .rd_ctx(rd_ctx), .rd_reg(rd_reg), .rd_data(rd_data));

   typedef struct {
      string       tag;
      logic [31:0] exp;
   } item_t;
   item_t sb_q[$];

   // reference state built from the requirements
   logic [31:0] m_crc [3];
   logic [31:0] m_seed[3];
   logic [1:0]  m_cfg [3];

   function automatic logic [31:0] m_mask(logic [1:0] code);
      return (code == 0) ? 32'hFF : (code == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
   endfunction

   function automatic logic [31:0] m_step(logic [31:0] c, logic [31:0] d, logic [1:0] code);
      int          w    = (code == 0) ? 8 : (code == 1) ? 16 : 32;
      logic [31:0] poly = (code == 0) ? 32'h1D : (code == 1) ? 32'h1021 : 32'h04C11DB7;
      logic [31:0] m    = m_mask(code);
      logic        fb;
      c = c & m;
      for (int i = 31; i >= 0; i--) begin
         fb = c[w-1] ^ d[i];
         c  = (c << 1) & m;
         if (fb) c = c ^ poly;
      end
      return c;
   endfunction

   function automatic logic [31:0] m_read(int ctx, int rg);
      if (ctx > 2) return 32'h0;
      case (rg)
         0: return m_crc[ctx] & m_mask(m_cfg[ctx]);
         1: return m_seed[ctx];
         2: return {30'h0, m_cfg[ctx]};
         default: return 32'h0;
      endcase
   endfunction

   task automatic wr(int ctx, int rg, logic [31:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_ctx  = 2'(ctx);
      wr_reg  = 2'(rg);
      wr_data = d;
      if (ctx <= 2) begin
         case (rg)
            0: m_crc[ctx] = m_step(m_crc[ctx], d, m_cfg[ctx]);
            1: begin m_seed[ctx] = d; m_crc[ctx] = d; end
            2: begin m_cfg[ctx] = d[1:0]; m_crc[ctx] = m_seed[ctx]; end
            default: ;
         endcase
      end
   endtask

   task automatic rd(int ctx, int rg, logic [31:0] exp, string tag);
      item_t it;
      @(negedge clk);
      wr_en  = 1'b0;
      rd_ctx = 2'(ctx);
      rd_reg = 2'(rg);
      it.tag = tag;
      it.exp = exp;
      sb_q.push_back(it);
   endtask

   task automatic rd_model(int ctx, int rg, string tag);
      rd(ctx, rg, m_read(ctx, rg), tag);
   endtask

   // monitor: sample just after the edge that follows each read request
   always @(posedge clk) begin
      #1;
      if (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         checks++;
         if (rd_data !== it.exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", it.tag, rd_data, it.exp);
         end
      end
   end

   task automatic finish_run();
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      for (int c = 0; c < 3; c++) begin
         m_crc[c] = '0; m_seed[c] = '0; m_cfg[c] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R8: reset state
      rd(0, 0, 32'h0, "R8 ctx0 checksum after reset");
      rd(2, 2, 32'h0, "R8 ctx2 config after reset");
      rd(1, 1, 32'h0, "R8 ctx1 seed after reset");

      // R2/R3: single trailing one bit from zero seed yields the polynomial
      wr(0, 2, 32'd0);
      wr(1, 2, 32'd1);
      wr(2, 2, 32'd2);
      wr(0, 0, 32'h1);
      wr(1, 0, 32'h1);
      wr(2, 0, 32'h1);
      rd(0, 0, 32'h1D, "R2 8-bit polynomial");
      rd(1, 0, 32'h1021, "R2 16-bit polynomial");
      rd(2, 0, 32'h04C11DB7, "R2 32-bit polynomial");

      // R5: seeds load immediately and read back in full
      wr(0, 1, 32'hFF);
      wr(1, 1, 32'hFFFF);
      wr(2, 1, 32'hFFFF_FFFF);
      rd(1, 0, 32'hFFFF, "R5 seed loads checksum");
      rd(2, 1, 32'hFFFF_FFFF, "R5 seed readback");

      // R4/R3/R1: interleaved ASCII words, one write every cycle
      wr(0, 0, 32'h31323334);
      wr(1, 0, 32'h31323334);
      wr(2, 0, 32'h31323334);
      wr(2, 0, 32'h35363738);
      wr(0, 0, 32'h35363738);
      wr(1, 0, 32'h35363738);
      wr(1, 0, 32'h39000000);
      wr(2, 0, 32'h39000000);
      wr(0, 0, 32'h39000000);
      rd_model(0, 0, "R4 interleaved stream ctx0");
      rd_model(1, 0, "R4 interleaved stream ctx1");
      rd_model(2, 0, "R3 interleaved stream ctx2");

      // R1: many writes to ctx2 leave ctx0/ctx1 intact
      for (int i = 0; i < 8; i++) wr(2, 0, 32'hA5A5_0000 + 32'(i));
      rd_model(0, 0, "R1 ctx0 untouched by ctx2 traffic");
      rd_model(1, 0, "R1 ctx1 untouched by ctx2 traffic");
      rd_model(2, 0, "R3 ctx2 after burst");

      // R7: width mask on a wide seed
      wr(1, 1, 32'hABCD_1234);
      rd(1, 0, 32'h0000_1234, "R7 16-bit result masked");
      wr(0, 1, 32'h1234_5678);
      rd(0, 0, 32'h0000_0078, "R7 8-bit result masked");

      // R6: config write reloads from seed, config reads back
      wr(1, 0, 32'hDEAD_BEEF);
      wr(1, 2, 32'd2);
      rd(1, 0, 32'hABCD_1234, "R6 reload from seed on width change");
      rd(1, 2, 32'd2, "R6 config readback");

      // R2: code 3 acts as 32-bit
      wr(0, 1, 32'h0);
      wr(0, 2, 32'd3);
      wr(0, 0, 32'h1);
      rd(0, 0, 32'h04C11DB7, "R2 code 3 is 32-bit");
      rd(0, 2, 32'd3, "R6 config code 3 readback");
      wr(0, 0, 32'hCAFE_F00D);
      rd_model(0, 0, "R3 32-bit from code 3 further word");

      // R9: absent context and unused selector
      wr(3, 1, 32'h5555_5555);
      wr(3, 0, 32'h1);
      wr(2, 3, 32'h7777_7777);
      rd(3, 0, 32'h0, "R9 absent context reads zero");
      rd(2, 3, 32'h0, "R9 unused selector reads zero");
      rd_model(0, 0, "R9 ctx0 unchanged by ignored writes");
      rd_model(1, 1, "R9 ctx1 seed unchanged by ignored writes");
      rd_model(2, 0, "R9 ctx2 checksum unchanged by ignored writes");

      @(negedge clk);
      repeat (3) @(posedge clk);
      #2;
      done = 1;
      finish_run();
   end

endmodule